// File: doc/BRIEF.md
# Serial Receiver with Wakeup Standby

This block turns an asynchronous serial line into 8- or 9-bit characters. A tick that runs at sixteen times the bit rate drives its timing. Each bit is judged by a majority vote of three samples taken around the middle of the bit. Each received character goes into a data register. Six status flags report the following conditions: a character is waiting, the line has gone idle, a character was lost to overrun, a noisy sample was seen, a stop bit was missing, and parity was wrong.

Software can put the receiver into standby. In standby, traffic meant for other listeners is thrown away, and neither the data register nor any flag changes. The receiver leaves standby by itself when the chosen hardware condition appears. The condition is either a quiet line lasting one character time, or a character whose most significant bit is 1. In the second case the waking character is received like any other. Software clears the flags by reading status while a flag is set and then reading data.

Top module: `uart_rx_standby`

## Requirements
- R1: While `rx_en` is 0, the receiver ignores `rxd` and abandons any character in progress. Data, flags and standby do not change.
- R2: A frame is one start bit (0), then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1), least significant bit first, then one stop bit (1). Each bit is sampled on ticks 7, 8 and 9 after the bit's first tick, and the majority of the three samples is the bit's value. The character appears on `rdata`, with bit 8 at 0 in 8-bit mode. Status bit 5 (data-full) sets when the character arrives. Status bits 7 and 6 always read 0. Everything is 0 after reset.
- R3: If the three samples of any bit in a character disagree, status bit 2 (noise) sets along with that character.
- R4: If the stop bit is judged 0, status bit 1 (framing error) sets. The character is still delivered.
- R5: When `par_en` is 1, the most significant data position holds the parity bit. Parity is even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets status bit 0.
- R6: If a character completes while data-full is still set, status bit 3 (overrun) sets and `rdata` keeps the older character.
- R7: A `stat_rd` pulse while any of status bits 5..0 is set, followed later by a `data_rd` pulse, clears status bits 5..0. A `data_rd` pulse with no such status read before it clears nothing.
- R8: Status bit 4 (idle) sets once after a stop bit has been followed by (data bits + 2) × 16 consecutive ticks of `rxd` at 1. Outside standby this happens at most once per received character.
- R9: A `stby_req` pulse while enabled sets `stby`. While `stby` is 1, a character that does not wake the receiver changes neither `rdata` nor any flag.
- R10: With `wake_mark`=0, a quiet line of one character time, counted from the standby request or the last stop bit, clears `stby`. The idle flag does not set.
- R11: With `wake_mark`=1, a character whose most significant data bit is 1 clears `stby` and is received normally. Characters with that bit at 0 are discarded, and a quiet line does not end standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input, idles high |
| rx_en | input | 1 | Receiver enable |
| stby_req | input | 1 | Pulse that enters standby |
| wake_mark | input | 1 | Wakeup select: 0 quiet line, 1 marked character |
| nine_bit | input | 1 | Character length: 0 eight bits, 1 nine bits |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rdata | output | 9 | Last received character |
| status | output | 8 | Flags: 5 full, 4 idle, 3 overrun, 2 noise, 1 framing, 0 parity |
| stby | output | 1 | Standby state |

## Verification
The assertions take four things for granted. First, `stat_rd` and `data_rd` never pulse in the same cycle. Second, a read or a `stby_req` never lands on the edge where a character completes or the idle count ends. Third, settings such as `nine_bit`, `par_en` and `wake_mark` change only while the line is quiet. Fourth, a character time has passed since the last stop bit when a read arrives. The stimulus meets all four. It issues reads and mode changes only after gaps longer than one character time. It starts frames on fixed negative edges, and it releases a bad stop bit before the next tick, so that no false start bit follows.

// File: rtl/uart_rx_standby.sv
module uart_rx_standby #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       stby_req,
  input  logic       wake_mark,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stat_rd,
  input  logic       data_rd,
  output logic [8:0] rdata,
  output logic [7:0] status,
  output logic       stby
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(12 * OSR);
  localparam logic [CW-1:0] S0   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S1   = CW'(OSR / 2);
  localparam logic [CW-1:0] S2   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] SEND = CW'(OSR - 1);

  logic          busy, nacc, idle_arm, rd_arm;
  logic [CW-1:0] sub;
  logic [3:0]    bidx;
  logic [1:0]    smp;
  logic [8:0]    sh;
  logic [IW-1:0] icnt;
  logic          full, idle, ovr, nf, fe, pf;

  wire [3:0]    nbits    = nine_bit ? 4'd9 : 4'd8;
  wire [IW-1:0] ilen     = IW'((nbits + 4'd2) * OSR);
  wire          maj      = (smp[0] & smp[1]) | (smp[0] & rxd) | (smp[1] & rxd);
  wire          disagree = !((smp[0] == smp[1]) && (smp[1] == rxd));
  wire          decide   = rx_en && busy && tick && sub == S2;
  wire          last     = bidx == nbits + 4'd1;
  wire          done     = decide && last;
  wire [8:0]    word     = nine_bit ? sh : {1'b0, sh[7:0]};
  wire          msb      = nine_bit ? sh[8] : sh[7];
  wire          nerr     = nacc | disagree;
  wire          perr     = par_en && ((^word) ^ par_odd);
  wire          accept   = done && (!stby || (wake_mark && msb));
  wire          idle_hit = rx_en && !busy && tick && idle_arm && rxd && icnt == ilen - 1'b1;
  wire          clr      = data_rd && rd_arm;

  assign status = {2'b00, full, idle, ovr, nf, fe, pf};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sub <= '0; bidx <= '0; smp <= '0; sh <= '0;
      nacc <= 1'b0; icnt <= '0; idle_arm <= 1'b0;
    end else if (!rx_en) begin
      busy <= 1'b0; idle_arm <= 1'b0;
    end else begin
      if (tick && !busy) begin
        if (!rxd) begin
          busy <= 1'b1; sub <= CW'(1); bidx <= '0; nacc <= 1'b0; sh <= '0;
        end
        if (idle_arm) begin
          if (!rxd) icnt <= '0;
          else if (icnt == ilen - 1'b1) idle_arm <= 1'b0;
          else icnt <= icnt + 1'b1;
        end
      end else if (tick) begin
        sub <= (sub == SEND) ? '0 : sub + 1'b1;
        if (sub == SEND) bidx <= bidx + 4'd1;
        if (sub == S0) smp[0] <= rxd;
        if (sub == S1) smp[1] <= rxd;
        if (decide) begin
          if (bidx == 4'd0 && maj) busy <= 1'b0;
          else begin
            nacc <= nerr;
            if (bidx != 4'd0 && !last) sh[bidx - 4'd1] <= maj;
            if (last) begin
              busy <= 1'b0; idle_arm <= 1'b1; icnt <= '0;
            end
          end
        end
      end
      if (stby_req) begin
        idle_arm <= 1'b1; icnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full <= 1'b0; idle <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; pf <= 1'b0;
      rd_arm <= 1'b0; rdata <= '0; stby <= 1'b0;
    end else begin
      if (data_rd) rd_arm <= 1'b0;
      if (stat_rd && |status[5:0]) rd_arm <= 1'b1;
      if (clr) begin
        full <= 1'b0; idle <= 1'b0; ovr <= 1'b0; nf <= 1'b0; fe <= 1'b0; pf <= 1'b0;
      end
      if (accept) begin
        if (full && !clr) ovr <= 1'b1;
        else begin
          full <= 1'b1; rdata <= word; nf <= nerr; fe <= !maj; pf <= perr;
        end
      end
      if (idle_hit && !stby) idle <= 1'b1;
      if ((idle_hit && stby && !wake_mark) || (accept && stby)) stby <= 1'b0;
      if (stby_req && rx_en) stby <= 1'b1;
    end

  AST_OFF_HALTS: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> !busy); // R1
  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rdata) |-> !$past(full)); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr) |-> $past(full)); // R6
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(full) |-> $past(data_rd)); // R7
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n) $rose(idle) |-> $past(rxd) && !$past(stby)); // R8
  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (stby && !wake_mark) |=> !$rose(full)); // R9
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(stby) |-> $past(idle_hit) || $past(accept)); // R10
endmodule

// File: tb/uart_rx_standby_test.sv
module uart_rx_standby_test;
  logic clk = 0, rst_n = 0, tick = 1, rxd = 1, rx_en = 1, stby_req = 0;
  logic wake_mark = 0, nine_bit = 0, par_en = 0, par_odd = 0, stat_rd = 0, data_rd = 0;
  logic [8:0] rdata;
  logic [7:0] status;
  logic stby;

  uart_rx_standby uut (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .stby_req(stby_req), .wake_mark(wake_mark), .nine_bit(nine_bit), .par_en(par_en),
    .par_odd(par_odd), .stat_rd(stat_rd), .data_rd(data_rd), .rdata(rdata),
    .status(status), .stby(stby));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, idle_left = 0;
  bit chk_on = 0, finished = 0;
  bit e_full = 0, e_idle = 0, e_ovr = 0, e_nf = 0, e_fe = 0, e_pf = 0, e_stby = 0, e_arm = 0;
  logic [8:0] e_data = 0;

  function automatic int char_ticks();
    return ((nine_bit ? 9 : 8) + 2) * 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk(status[5] == e_full, "R2 full", status[5], e_full);
    chk(status[4] == e_idle, "R8 idle", status[4], e_idle);
    chk(status[3] == e_ovr,  "R6 overrun", status[3], e_ovr);
    chk(status[2] == e_nf,   "R3 noise", status[2], e_nf);
    chk(status[1] == e_fe,   "R4 framing", status[1], e_fe);
    chk(status[0] == e_pf,   "R5 parity", status[0], e_pf);
    chk(status[7:6] == 2'b00, "R2 upper", status[7:6], 0);
    chk(rdata == e_data,     "R2 data", rdata, e_data);
    chk(stby == e_stby,      "R9 standby", stby, e_stby);
  end

  always @(posedge clk) if (idle_left > 0) begin
    idle_left--;
    if (idle_left == 0) begin
      if (!e_stby) e_idle = 1;
      else if (!wake_mark) e_stby = 0;
    end
  end

  task automatic finish_char(input logic [8:0] d, input bit noisy, input bit badstop);
    int n = nine_bit ? 9 : 8;
    logic [8:0] w = nine_bit ? d : {1'b0, d[7:0]};
    bit top = w[n-1];
    idle_left = char_ticks();
    if (e_stby && !(wake_mark && top)) return;
    e_stby = 0;
    if (e_full) e_ovr = 1;
    else begin
      e_full = 1; e_data = w; e_nf = noisy; e_fe = badstop;
      e_pf = par_en && ((^w) ^ par_odd);
    end
  endtask

  task automatic send(input logic [8:0] d, input int gl, input bit badstop, input bit live);
    int n = nine_bit ? 9 : 8;
    logic v;
    for (int b = 0; b < n + 2; b++) begin
      v = (b == 0) ? 1'b0 : (b == n + 1) ? !badstop : d[b-1];
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (b == 0 && k == 0) idle_left = 0;
        if (b == gl && k == 8) rxd = !v;
        else if (badstop && b == n + 1 && k >= 10) rxd = 1'b1;
        else rxd = v;
        if (b == n + 1 && k == 9) begin
          @(posedge clk); #1;
          if (live) finish_char(d, gl >= 0, badstop);
        end
      end
    end
    @(negedge clk) rxd = 1'b1;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_stat();
    @(negedge clk) stat_rd = 1;
    @(posedge clk); #1;
    if (e_full | e_idle | e_ovr | e_nf | e_fe | e_pf) e_arm = 1;
    @(negedge clk) stat_rd = 0;
  endtask

  task automatic rd_data();
    @(negedge clk) data_rd = 1;
    @(posedge clk); #1;
    if (e_arm) begin
      e_full = 0; e_idle = 0; e_ovr = 0; e_nf = 0; e_fe = 0; e_pf = 0;
    end
    e_arm = 0;
    @(negedge clk) data_rd = 0;
  endtask

  task automatic clear_all();
    rd_stat(); rd_data(); gap(2);
    chk(status[5:0] == 0, "R7 clear", status[5:0], 0);
  endtask

  task automatic enter_stby();
    @(negedge clk) stby_req = 1;
    @(posedge clk); #1;
    e_stby = 1; idle_left = char_ticks();
    @(negedge clk) stby_req = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk(status == 0 && rdata == 0 && stby == 0, "R2 reset", status, 0);
    chk_on = 1;
    gap(4);

    send(9'h0A5, -1, 0, 1); gap(20);
    chk(status[5] && rdata == 9'h0A5, "R2 8-bit char", rdata, 9'h0A5);
    gap(200);
    chk(status[4] == 1, "R8 idle after char", status[4], 1);
    clear_all();
    gap(400);
    chk(status[4] == 0, "R8 idle once per char", status[4], 0);

    send(9'h03C, -1, 0, 1); send(9'h05A, -1, 0, 1); gap(200);
    chk(status[3] && rdata == 9'h03C, "R6 overrun keeps data", rdata, 9'h03C);
    rd_data(); gap(2);
    chk(status[5] == 1, "R7 data read alone", status[5], 1);
    clear_all();

    send(9'h066, 3, 0, 1); gap(200);
    chk(status[2] == 1, "R3 noise", status[2], 1);
    clear_all();

    send(9'h0F0, -1, 1, 1); gap(200);
    chk(status[1] == 1 && rdata == 9'h0F0, "R4 framing", status, 9'h0F0);
    clear_all();

    par_en = 1;
    send(9'h081, -1, 0, 1); gap(200);
    chk(status[0] == 0, "R5 even ok", status[0], 0);
    clear_all();
    send(9'h001, -1, 0, 1); gap(200);
    chk(status[0] == 1, "R5 even error", status[0], 1);
    clear_all();
    par_odd = 1;
    send(9'h001, -1, 0, 1); gap(200);
    chk(status[0] == 0, "R5 odd ok", status[0], 0);
    clear_all();
    par_en = 0; par_odd = 0;

    nine_bit = 1;
    send(9'h1F3, -1, 0, 1); gap(250);
    chk(rdata == 9'h1F3, "R2 9-bit char", rdata, 9'h1F3);
    clear_all();
    nine_bit = 0;

    @(negedge clk) rx_en = 0; idle_left = 0;
    send(9'h055, -1, 0, 0); gap(200);
    chk(status[5:0] == 0 && rdata == 9'h1F3, "R1 disabled", rdata, 9'h1F3);
    @(negedge clk) rx_en = 1;
    gap(20);

    wake_mark = 0;
    enter_stby();
    send(9'h011, -1, 0, 1); gap(20);
    chk(status[5] == 0 && stby == 1, "R9 discarded", status, 0);
    gap(200);
    chk(stby == 0 && status[4] == 0, "R10 idle wake", {stby, status[4]}, 0);

    wake_mark = 1;
    enter_stby();
    send(9'h012, -1, 0, 1); gap(250);
    chk(stby == 1 && status[5] == 0, "R11 unmarked kept in standby", stby, 1);
    send(9'h085, -1, 0, 1); gap(20);
    chk(stby == 0 && status[5] && rdata == 9'h085, "R11 marked wake", rdata, 9'h085);
    gap(200);
    clear_all();
    wake_mark = 0;

    gap(10);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule